// File: doc/BRIEF.md
# Byte-Loaded Interval Counter Channel

This block is a single channel of an interval timer. A 16-bit down-counter is advanced by a slow count clock that arrives on its own pin. Software talks to the channel over an 8-bit write/read port with two addresses: one for a control byte and one for count data. The control byte picks how count bytes are framed: low byte only, high byte only, or low then high. The channel runs one mode only. The output pin drops when software programs the channel and rises when the count reaches zero.

The count clock is brought into the bus clock domain and reduced to rise and fall events. Count bytes gather in a holding register. A completed count moves into the counter only after the write has finished and the count clock has made a full rise-then-fall cycle. In the two-byte framing, the first byte freezes the running count and the second byte arms the new value. A control byte written while the channel runs does not stop the old count.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is low, the counter reads 0000h, and count-clock cycles leave the count unchanged until a first count has been loaded. The reset framing is low-then-high.
- R2: A control byte is written with `bus_addr`=1. Its bits [5:4] select the framing: 01 low byte only, 10 high byte only, 11 low then high. Such a write drives the output low, resets both byte toggles, discards any partly written or not yet loaded count, and resumes a count frozen by a first byte. A control byte with bits [5:4]=00 has no effect at all.
- R3: In low-only framing a data byte becomes count {00h, byte}. In high-only framing it becomes {byte, 00h}. Each of these single-byte writes completes a count.
- R4: In low-then-high framing, the first data byte freezes decrementing and the count stays frozen. The second byte completes the count.
- R5: A completed count enters the counter only on the first count-clock fall that follows a count-clock rise seen after the write. That fall loads the value without decrementing it, and each later fall decrements it by one.
- R6: Writing a control byte to a running channel does not stop it. The old value keeps decrementing.
- R7: The output goes high on the fall that brings the count to zero. It stays high while the counter wraps from 0000h to FFFFh and keeps counting. It goes low again only when a count is completed or a control byte is written.
- R8: A loaded count of 0000h is the longest period. The next fall gives FFFFh and the output stays low.
- R9: Reads use `bus_addr`=0. In low-then-high framing, successive reads return the low byte and then the high byte of the live count. In the single-byte framings every read returns the selected byte.
- R10: If a second count is completed after a count-clock rise but before the matching fall, that fall loads nothing. A fresh rise-then-fall is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cnt_clk | input | 1 | Count clock, sampled into the clk domain |
| bus_wr | input | 1 | Write strobe, one clk cycle per byte |
| bus_addr | input | 1 | 1 selects the control byte, 0 selects count data |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe for count data, advances the read toggle |
| bus_rdata | output | 8 | Selected byte of the live count |
| timer_out | output | 1 | Terminal-count output |

## Verification
A wrong internal state shows up at the pins within one count-clock cycle. A load that comes too early, or one not cancelled, shows up in the next two-byte readback as the new value where the old frozen one should be. A missed freeze shows up as a count one lower after a single tick. A byte toggle that drifts swaps the two readback bytes at once, and it makes a later high byte land in the low half of the count. A misplaced zero detection appears as `timer_out` rising one tick early or late, or falling on the wrap through FFFFh.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // framing selector carried in the control byte
   typedef enum logic [1:0] {
      RL_NONE = 2'b00,
      RL_LO   = 2'b01,
      RL_HI   = 2'b10,
      RL_BOTH = 2'b11
   } rl_e;

   localparam int RL_POS = 4;   // bit position of the framing field
endpackage

// File: rtl/pit_edge_sync.sv
module pit_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 0 || STAGES > 8) begin : g_bad_stages
      $error("pit_edge_sync: STAGES out of range");
   end

   logic sync_s;
   logic prev_q;

   if (STAGES == 0) begin : g_direct
      assign sync_s = async_i;
   end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q[0] <= 1'b0;
         else        sh_q[0] <= async_i;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
      assign sync_s = sh_q[STAGES-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_s;
   end

   assign rise_o = sync_s & ~prev_q;
   assign fall_o = ~sync_s & prev_q;
endmodule

// File: rtl/pit_bus_if.sv
module pit_bus_if
   import pit_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             addr_i,
   input  logic [BUS_W-1:0] wdata_i,
   input  logic             rd_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             ctrl_wr_o,
   output logic             halt_o,
   output logic             done_o,
   output logic [CNT_W-1:0] hold_o,
   output logic [BUS_W-1:0] rdata_o
);
   localparam int HI_LSB = BUS_W;
   localparam int HI_MSB = CNT_W - 1;

   if (CNT_W != 2 * BUS_W || BUS_W < RL_POS + 2) begin : g_bad_width
      $error("pit_bus_if: CNT_W must be twice BUS_W and BUS_W wide enough");
   end

   rl_e              rl_q;
   logic             wtog_q;
   logic             rtog_q;
   logic [CNT_W-1:0] hold_q;
   rl_e              rl_field;
   logic             ctrl_fire;
   logic             data_fire;
   logic             rd_fire;

   assign rl_field  = rl_e'(wdata_i[RL_POS +: 2]);
   assign ctrl_fire = wr_i && addr_i && (rl_field != RL_NONE);
   assign data_fire = wr_i && !addr_i;
   assign rd_fire   = rd_i && !addr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rl_q   <= RL_BOTH;
         wtog_q <= 1'b0;
         rtog_q <= 1'b0;
         hold_q <= '0;
      end else if (ctrl_fire) begin
         rl_q   <= rl_field;
         wtog_q <= 1'b0;
         rtog_q <= 1'b0;
      end else begin
         if (data_fire) begin
            unique case (rl_q)
               RL_LO: hold_q <= {{BUS_W{1'b0}}, wdata_i};
               RL_HI: hold_q <= {wdata_i, {BUS_W{1'b0}}};
               default: begin
                  if (!wtog_q) hold_q[BUS_W-1:0]     <= wdata_i;
                  else         hold_q[HI_MSB:HI_LSB] <= wdata_i;
                  wtog_q <= ~wtog_q;
               end
            endcase
         end
         if (rd_fire && rl_q == RL_BOTH) rtog_q <= ~rtog_q;
      end
   end

   assign ctrl_wr_o = ctrl_fire;
   assign halt_o    = data_fire && (rl_q == RL_BOTH) && !wtog_q;
   assign done_o    = data_fire && ((rl_q != RL_BOTH) || wtog_q);
   assign hold_o    = hold_q;

   always_comb begin
      unique case (rl_q)
         RL_LO:   rdata_o = count_i[BUS_W-1:0];
         RL_HI:   rdata_o = count_i[HI_MSB:HI_LSB];
         default: rdata_o = rtog_q ? count_i[HI_MSB:HI_LSB] : count_i[BUS_W-1:0];
      endcase
   end

   // R9: byte toggles only move in the two-byte framing
   p_toggle_two_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wtog_q || rtog_q) |-> (rl_q == RL_BOTH));

   // R2: an ignored control byte leaves the framing as it was
   p_null_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i && rl_field == RL_NONE) |=> $stable(rl_q));
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr_i,
   input  logic             halt_i,
   input  logic             done_i,
   input  logic [CNT_W-1:0] hold_i,
   input  logic             rise_i,
   input  logic             fall_i,
   output logic [CNT_W-1:0] count_o,
   output logic             out_o
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pit_count_core: CNT_W too small");
   end

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_nx;
   logic             running_q;
   logic             halted_q;
   logic             pend_q;
   logic             phase_q;
   logic             out_q;
   logic             load_ok;
   logic             dec_fire;

   assign count_nx = count_q - ONE;
   assign load_ok  = pend_q && phase_q && fall_i && !ctrl_wr_i;
   assign dec_fire = fall_i && running_q && !halted_q && !load_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q   <= '0;
         running_q <= 1'b0;
      end else if (load_ok) begin
         count_q   <= hold_i;
         running_q <= 1'b1;
      end else if (dec_fire) begin
         count_q   <= count_nx;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         halted_q <= 1'b0;
      else if (ctrl_wr_i) halted_q <= 1'b0;
      else if (halt_i)    halted_q <= 1'b1;
      else if (load_ok)   halted_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (ctrl_wr_i) begin
         pend_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (done_i) begin
         pend_q  <= 1'b1;
         phase_q <= 1'b0;
      end else if (load_ok) begin
         pend_q  <= 1'b0;
         phase_q <= 1'b0;
      end else if (pend_q && rise_i) begin
         phase_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        out_q <= 1'b0;
      else if (ctrl_wr_i || done_i)      out_q <= 1'b0;
      else if (dec_fire && count_nx == ZERO) out_q <= 1'b1;
   end

   assign count_o = count_q;
   assign out_o   = out_q;

   // R1: nothing moves the counter before a first load is armed
   p_idle_until_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !pend_q) |=> $stable(count_q));

   // R2: a control byte always leaves the output low
   p_ctrl_out_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr_i |=> !out_q);

   // R4: a frozen count with no armed load holds still
   p_halt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !pend_q) |=> $stable(count_q));

   // R5: counting begins only after a qualifying rise was seen
   p_load_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running_q) |-> $past(phase_q));

   // R7: the output rises only at a zero count
   p_out_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q) |-> (count_q == ZERO));
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
   parameter int BUS_W       = 8,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_clk,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [BUS_W-1:0] bus_wdata,
   input  logic             bus_rd,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             timer_out
);
   logic             rise_s;
   logic             fall_s;
   logic             ctrl_wr_s;
   logic             halt_s;
   logic             done_s;
   logic [CNT_W-1:0] hold_s;
   logic [CNT_W-1:0] count_s;

   pit_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (cnt_clk),
      .rise_o  (rise_s),
      .fall_o  (fall_s)
   );

   pit_bus_if #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .rd_i      (bus_rd),
      .count_i   (count_s),
      .ctrl_wr_o (ctrl_wr_s),
      .halt_o    (halt_s),
      .done_o    (done_s),
      .hold_o    (hold_s),
      .rdata_o   (bus_rdata)
   );

   pit_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr_i (ctrl_wr_s),
      .halt_i    (halt_s),
      .done_i    (done_s),
      .hold_i    (hold_s),
      .rise_i    (rise_s),
      .fall_i    (fall_s),
      .count_o   (count_s),
      .out_o     (timer_out)
   );
endmodule

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
module pit_channel_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cnt_clk = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_rdata;
   logic       timer_out;
   logic       probe = 1'b0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   typedef struct {
      int         req;
      bit         is_out;
      logic [7:0] exp;
   } item_t;
   item_t exp_q[$];

   always #2 clk = ~clk;

   pit_channel dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_clk   (cnt_clk),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .timer_out (timer_out)
   );

   // monitor: pops the scoreboard when the design presents a result
   always @(negedge clk) begin
      if (rst_n && ((bus_rd && !bus_addr) || probe)) begin
         item_t it;
         logic [7:0] act;
         act = probe ? {7'd0, timer_out} : bus_rdata;
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R0 unexpected result actual=%h expected=none", act);
         end else begin
            it = exp_q.pop_front();
            if (act !== it.exp) begin
               n_fail++;
               $display("FAIL R%0d %s actual=%h expected=%h", it.req,
                        it.is_out ? "out" : "read", act, it.exp);
            end
         end
      end
   end

   task automatic wr(input logic a, input logic [7:0] d);
      @(posedge clk); #1;
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_addr = 1'b0;
   endtask

   task automatic rd_byte(input int req, input logic [7:0] e);
      exp_q.push_back('{req: req, is_out: 1'b0, exp: e});
      @(posedge clk); #1;
      bus_rd = 1'b1; bus_addr = 1'b0;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic rd16(input int req, input logic [15:0] e);
      rd_byte(req, e[7:0]);
      rd_byte(req, e[15:8]);
   endtask

   task automatic chk_out(input int req, input logic e);
      exp_q.push_back('{req: req, is_out: 1'b1, exp: {7'd0, e}});
      @(posedge clk); #1;
      probe = 1'b1;
      @(posedge clk); #1;
      probe = 1'b0;
   endtask

   task automatic cnt_level(input logic v);
      @(posedge clk); #1;
      cnt_clk = v;
      repeat (4) @(posedge clk);
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         cnt_level(1'b1);
         cnt_level(1'b0);
      end
   endtask

   task automatic summary;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL R0 watchdog expired actual=running expected=done");
         summary();
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: idle after reset
      chk_out(1, 1'b0);
      tick(1);
      rd16(1, 16'h0000);

      // R5: load on rise-then-fall, no decrement on the load fall
      wr(1'b1, 8'h30);
      wr(1'b0, 8'h05); wr(1'b0, 8'h00);
      chk_out(5, 1'b0);
      tick(1);
      rd16(5, 16'h0005);
      tick(1);
      rd16(5, 16'h0004);
      tick(3);
      chk_out(7, 1'b0);
      // R7: terminal count and wrap
      tick(1);
      chk_out(7, 1'b1);
      rd16(7, 16'h0000);
      tick(1);
      chk_out(7, 1'b1);
      rd16(7, 16'hFFFF);
      // R2: control byte drops the output
      wr(1'b1, 8'h30);
      chk_out(2, 1'b0);
      tick(1);                 // R6: keeps running after control byte
      rd16(6, 16'hFFFE);

      // R8: zero count
      wr(1'b0, 8'h00); wr(1'b0, 8'h00);
      tick(1);
      tick(1);
      chk_out(8, 1'b0);
      rd16(8, 16'hFFFF);

      // R4: first byte freezes, second arms
      wr(1'b0, 8'h10);
      tick(2);
      rd16(4, 16'hFFFF);
      wr(1'b0, 8'h00);
      tick(1);
      tick(1);
      rd16(4, 16'h000F);

      // R6: control byte on a running channel
      wr(1'b1, 8'h30);
      tick(1);
      rd16(6, 16'h000E);
      // R2: control byte resumes a frozen count and drops the half write
      wr(1'b0, 8'h33);
      wr(1'b1, 8'h30);
      tick(1);
      rd16(2, 16'h000D);

      // R3 / R9: single-byte framings
      wr(1'b1, 8'h10);
      wr(1'b0, 8'h07);
      tick(1);
      rd_byte(3, 8'h07);
      tick(1);
      rd_byte(9, 8'h06);
      rd_byte(9, 8'h06);
      wr(1'b1, 8'h20);
      wr(1'b0, 8'h02);
      tick(1);
      rd_byte(3, 8'h02);
      wr(1'b1, 8'h30);
      tick(1);
      rd16(9, 16'h01FF);

      // R10: completing a count between rise and fall restarts qualification
      wr(1'b0, 8'h20); wr(1'b0, 8'h00);
      cnt_level(1'b1);
      wr(1'b0, 8'h30); wr(1'b0, 8'h00);
      cnt_level(1'b0);
      rd16(10, 16'h01FF);
      tick(1);
      rd16(10, 16'h0030);

      // R2: control byte with null framing is ignored
      wr(1'b0, 8'h44);
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h00);
      tick(1);
      rd16(2, 16'h0044);
      chk_out(2, 1'b0);

      repeat (4) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R0 unmatched expectations actual=%0d expected=0", exp_q.size());
      end
      finished = 1'b1;
      summary();
   end
endmodule